// File: doc/BRIEF.md
# Sustained-High Halt Qualifier

The block watches a single level input that may be asynchronous to the clock and raises a halt request for a processor only once that input has been seen high without interruption for a programmed number of samples. The input first passes through a flop chain that resynchronises it. A run-length counter then advances on every qualifying high sample and saturates at the target. The registered request rises when the target is reached, stays up while the input stays high, and drops as soon as a low sample arrives. A low sample at any earlier point throws away all progress at once.

For long qualifying times an optional prescaler turns the clock into a sampling enable. The counter and the request then move only on enabled cycles, so the counter needs fewer bits, at the cost of coarser timing. The synchroniser delay only adds to the time the raw input must already have been high, so the configured minimum is never shortened. With the defaults (250 MHz clock, target 5, no prescale, two synchroniser stages), a raw high first sampled at edge a raises the request just after edge a+6.

Top module: `halt_hold_qualifier`

## Requirements
- R1: During and right after a synchronous reset (`rst` high at a rising edge), `halt_req` is 0, the run counter is 0 and the synchroniser stages are 0.
- R2: A raw high lasting RUN_TARGET-1 sampled edges, or any shorter run, never raises `halt_req`.
- R3: With PRESCALE=1, a raw high first sampled at edge a and held raises `halt_req` right after edge a+RUN_TARGET+1. The counter sees the input SYNC_DEPTH=2 edges late, and `halt_req` is never high before that edge.
- R4: While the raw input stays high after qualification, `halt_req` stays 1 and the counter saturates at RUN_TARGET.
- R5: A raw low first sampled at edge b clears `halt_req` right after edge b+2, and not before.
- R6: A single low sample inside a high run resets the count to zero, so a full RUN_TARGET of new high samples is needed after it.
- R7: With RUN_TARGET of 0 or 1, `halt_req` follows the synchronised input one register later.
- R8: With PRESCALE=P>1, the enable is high on edges n with n mod P = P-1, where n counts edges from 0 after reset is released. The counter and `halt_req` change only on enabled edges, and a low seen between enabled edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Level to qualify, may be asynchronous |
| halt_req | output | 1 | Registered halt request |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before any check matters, and that `raw_in` changes only away from the rising edge. The bench meets this by driving every input on the falling edge. The saturation and drop properties assume the counter enable comes only from the internal prescaler. The random stimulus holds each raw level for 1 to 12 cycles, so runs just short of, equal to and longer than the target all occur, both on and between prescaler enables.

// File: rtl/halt_qual_pkg.sv
package halt_qual_pkg;

    // width of a counter that must hold values 0..limit
    function automatic int cnt_bits(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/hq_sync.sv
module hq_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [DEPTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.stage = {st_q.stage[DEPTH-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.stage[DEPTH-1];

    genvar gi;
    generate
        for (gi = 1; gi < DEPTH; gi++) begin : g_chk
            // R3: each stage carries the previous stage one edge later
            a_r3_stage_shift: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> st_q.stage[gi] == $past(st_q.stage[gi-1]));
        end
    endgenerate
endmodule

// File: rtl/hq_tick.sv
module hq_tick #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int LAST  = (DIV <= 1) ? 0 : DIV - 1;
    localparam int DIV_W = halt_qual_pkg::cnt_bits(LAST);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == DIV_W'(LAST)) st_d.phase = '0;
        else                            st_d.phase = st_q.phase + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick = (st_q.phase == DIV_W'(LAST));

    generate
        if (DIV > 1) begin : g_spaced
            // R8: enables never occur on two edges in a row when dividing
            a_r8_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/hq_run.sv
module hq_run #(
    parameter int TGT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic [halt_qual_pkg::cnt_bits(TGT)-1:0] cnt
);
    localparam int CNT_W = halt_qual_pkg::cnt_bits(TGT);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(TGT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (!din)               st_d.cnt = '0;
            else if (st_q.cnt != TOP) st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R6: a low on an enabled sample wipes the count
    a_r6_low_clears: assert property (@(posedge clk) disable iff (rst)
        (en && !din) |=> (cnt == '0));
    // R4: the count never passes the target
    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);
    // R8: without an enable the count is frozen
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));
endmodule

// File: rtl/halt_hold_qualifier.sv
module halt_hold_qualifier #(
    parameter int RUN_TARGET = 5,
    parameter int PRESCALE   = 1,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic halt_req
);
    localparam int CNT_W = halt_qual_pkg::cnt_bits(RUN_TARGET);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(RUN_TARGET);

    logic             synced;
    logic             sample_en;
    logic [CNT_W-1:0] run_cnt;

    typedef struct packed {
        logic req;
    } top_state_t;

    top_state_t st_d, st_q;

    hq_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (synced)
    );

    hq_tick #(.DIV(PRESCALE)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (sample_en)
    );

    hq_run #(.TGT(RUN_TARGET)) u_run (
        .clk (clk),
        .rst (rst),
        .en  (sample_en),
        .din (synced),
        .cnt (run_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (sample_en)
            st_d.req = synced && ((int'(run_cnt) + 1) >= RUN_TARGET);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign halt_req = st_q.req;

    // R2: the request can only rise once the run count has reached the target
    a_r2_rise_at_full: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_req) |-> (run_cnt == TOP));
    // R5: an enabled low sample drops the request on the next edge
    a_r5_drop_on_low: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !synced) |=> !halt_req);
    // R4: a held request survives an enabled high sample
    a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
        (halt_req && sample_en && synced) |=> halt_req);
    // R8: the request only moves on enabled edges
    a_r8_req_gated: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(halt_req));
endmodule

// File: tb/test_halt_hold_qualifier.sv
module test_halt_hold_qualifier;
    localparam int NI = 3;
    localparam int TG [NI] = '{5, 4, 1};
    localparam int PS [NI] = '{1, 3, 1};
    localparam int T0 = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw = 1'b0;
    logic [NI-1:0] req;

    int checks = 0;
    int fails  = 0;
    string tag0 = "R1";
    bit    live = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    halt_hold_qualifier #(.RUN_TARGET(5), .PRESCALE(1)) i_halt_hold_qualifier (
        .clk(clk), .rst(rst), .raw_in(raw), .halt_req(req[0]));
    halt_hold_qualifier #(.RUN_TARGET(4), .PRESCALE(3)) i_halt_hold_qualifier_pre (
        .clk(clk), .rst(rst), .raw_in(raw), .halt_req(req[1]));
    halt_hold_qualifier #(.RUN_TARGET(1), .PRESCALE(1)) i_halt_hold_qualifier_t1 (
        .clk(clk), .rst(rst), .raw_in(raw), .halt_req(req[2]));

    // spec model: two edges of latency, enable schedule, saturating run
    bit h1 [NI];
    bit h2 [NI];
    int n  [NI];
    int run[NI];
    bit exp_req[NI];

    function automatic int next_run(input int r, input bit hi, input int t);
        if (!hi) return 0;
        return (r >= t) ? t : r + 1;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < NI; i++) begin
            if (rst) begin
                h1[i] = 0; h2[i] = 0; n[i] = 0; run[i] = 0; exp_req[i] = 0;
            end else begin
                bit dl;
                bit en;
                dl = h2[i];
                h2[i] = h1[i];
                h1[i] = raw;
                en = (PS[i] <= 1) || ((n[i] % PS[i]) == PS[i] - 1);
                n[i]++;
                if (en) begin
                    run[i] = next_run(run[i], dl, TG[i]);
                    exp_req[i] = dl && (run[i] >= TG[i]);
                end
            end
        end
    end

    task automatic check(input string r, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: halt_req actual=%0b expected=%0b at %0t", r, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            check(tag0, req[0], exp_req[0]);
            check("R8", req[1], exp_req[1]);
            check("R7", req[2], exp_req[2]);
        end
    end

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic idle();
        raw = 1'b0;
        tick(10);
    endtask

    initial begin
        int seen;
        tick(3);
        check("R1", req[0], 1'b0);
        check("R1", req[1], 1'b0);
        check("R1", req[2], 1'b0);
        rst = 1'b0;
        tick(1);
        check("R1", req[0], 1'b0);
        live = 1'b1;
        idle();

        // R2: one sample short of the target
        tag0 = "R2";
        raw = 1'b1;
        tick(T0 - 1);
        raw = 1'b0;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (req[0]) seen++;
        end
        check("R2", seen != 0, 1'b0);

        // R2/R3: exactly the target gives a single-cycle request
        tag0 = "R3";
        raw = 1'b1;
        tick(T0);
        raw = 1'b0;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (req[0]) seen++;
        end
        check("R3", seen == 1, 1'b1);
        idle();

        // R3: exact rise edge, R4: hold, R5: exact drop edge
        raw = 1'b1;
        tick(T0 + 1);
        check("R3", req[0], 1'b0);
        tick(1);
        check("R3", req[0], 1'b1);
        tag0 = "R4";
        tick(25);
        check("R4", req[0], 1'b1);
        tag0 = "R5";
        raw = 1'b0;
        tick(2);
        check("R5", req[0], 1'b1);
        tick(1);
        check("R5", req[0], 1'b0);
        idle();

        // R6: one-cycle dropout restarts the run
        tag0 = "R6";
        raw = 1'b1;
        tick(T0 - 1);
        raw = 1'b0;
        tick(1);
        raw = 1'b1;
        tick(T0 + 1);
        check("R6", req[0], 1'b0);
        tick(1);
        check("R6", req[0], 1'b1);
        idle();

        // R7: target 1 follows the input with latency
        raw = 1'b1;
        tick(2);
        check("R7", req[2], 1'b0);
        tick(1);
        check("R7", req[2], 1'b1);
        idle();

        // random runs, model compared every cycle
        tag0 = "R4";
        void'($urandom(32'h1d5c_0a77));
        for (int k = 0; k < 600; k++) begin
            raw = $urandom_range(1, 0);
            tick($urandom_range(12, 1));
        end
        idle();
        live = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule